// File: doc/BRIEF.md
# Single-Cycle Datapath Control Decoder

This block is the purely combinational steering logic of a single-cycle processor core. Each cycle it takes the decoded opcode class and function code of the current instruction, the two register specifiers, the operand words read from the register file, the constant word, the fall-through address, the ALU result, the word read from data memory and the branch-taken flag. From these it derives the register-file read and write addresses, both ALU operands and the ALU function, the condition-code load strobe, the data-memory strobes, address and write data, and the address of the next instruction.

Every output is a priority selection keyed on the opcode class. The stack-manipulating instructions (push, pop, call, return) move the stack pointer through the ALU by a constant of plus or minus four. Pop writes two registers in the same cycle: the stack pointer on the ALU-result port and the popped word on the memory port. The register file, ALU and memories sit outside the block, and it holds no state.

Top module: `sc_ctrl_decode`

## Requirements
- R1: Opcode class codes are halt 0x0, nop 0x1, reg-to-reg move 0x2, immediate-to-reg 0x3, reg-to-mem 0x4, mem-to-reg 0x5, arithmetic/logic op 0x6, jump 0x7, call 0x8, return 0x9, push 0xA, pop 0xB; codes 0xC to 0xF are invalid. Register ID 0xF means "no register" and ID 4 is the stack pointer. Read address A is rA for move, reg-to-mem, op and push; 4 for pop and return; 0xF otherwise.
- R2: Read address B is rB for op, reg-to-mem and mem-to-reg; 4 for push, pop, call and return; 0xF otherwise.
- R3: The ALU-result write address is rB for move, immediate and op; 4 for push, pop, call and return; 0xF otherwise.
- R4: The memory-result write address is rA for mem-to-reg and pop, 0xF otherwise, so pop writes the stack pointer and rA in the same cycle.
- R5: ALU operand A is valA for move and op; valC for immediate, reg-to-mem and mem-to-reg; -4 for call and push; +4 for return and pop; 0 otherwise.
- R6: ALU operand B is 0 for move and immediate and valB for every other code.
- R7: The ALU function equals ifun for op and is add (code 0) for all others; the condition-code load strobe is high only for op.
- R8: Memory read is high only for mem-to-reg, pop and return; memory write is high only for reg-to-mem, push and call; never both.
- R9: The memory address is valE for reg-to-mem, push, call and mem-to-reg, valA for pop and return, 0 otherwise; write data is valP for call and valA otherwise.
- R10: The next PC is valC for call, valC for a jump with the branch flag high, valM for return, and valP otherwise (including a jump with the flag low).
- R11: Halt, nop and the invalid codes write no register, access no memory, load no condition codes and advance to valP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| icode | input | 4 | Opcode class |
| ifun | input | 4 | Function code |
| ra | input | 4 | First register specifier |
| rb | input | 4 | Second register specifier |
| val_a | input | WORD_W | Register-file read data A |
| val_b | input | WORD_W | Register-file read data B |
| val_c | input | WORD_W | Constant word of the instruction |
| val_p | input | WORD_W | Fall-through address |
| val_e | input | WORD_W | ALU result |
| val_m | input | WORD_W | Data-memory read word |
| br_taken | input | 1 | Branch condition is met |
| src_a | output | 4 | Register read address A |
| src_b | output | 4 | Register read address B |
| dst_e | output | 4 | Write address for the ALU result |
| dst_m | output | 4 | Write address for the memory word |
| alu_a | output | WORD_W | ALU operand A |
| alu_b | output | WORD_W | ALU operand B |
| alu_fn | output | 4 | ALU function code |
| cc_load | output | 1 | Load condition codes |
| mem_rd | output | 1 | Data-memory read enable |
| mem_wr | output | 1 | Data-memory write enable |
| mem_addr | output | WORD_W | Data-memory address |
| mem_wdata | output | WORD_W | Data-memory write data |
| pc_next | output | WORD_W | Address of the next instruction |

## Verification
All sixteen opcode codes are swept under several specifier patterns: rA and rB set to ordinary registers, to the stack-pointer ID and to the no-register ID, so a decoder that confuses rA with rB or the stack pointer with a specifier gives a different address. The data words are all distinct per cycle, which shows which source every word-wide mux picked, and the branch flag alternates, separating a taken jump from a fall-through. The invalid codes and halt and nop are checked for the absence of any write or memory access.

// File: rtl/sc_ctrl_pkg.sv
package sc_ctrl_pkg;
  localparam int unsigned RID_W = 4;
  localparam int unsigned FN_W  = 4;

  typedef enum logic [3:0] {
    OPC_HALT  = 4'h0,
    OPC_NOP   = 4'h1,
    OPC_RRMV  = 4'h2,
    OPC_IRMV  = 4'h3,
    OPC_RMMV  = 4'h4,
    OPC_MRMV  = 4'h5,
    OPC_ALU   = 4'h6,
    OPC_JMP   = 4'h7,
    OPC_CALL  = 4'h8,
    OPC_RET   = 4'h9,
    OPC_PUSH  = 4'hA,
    OPC_POP   = 4'hB
  } opc_e;

  localparam logic [RID_W-1:0] RID_SP   = 4'h4;
  localparam logic [RID_W-1:0] RID_NONE = 4'hF;
  localparam logic [FN_W-1:0]  FN_ADD   = 4'h0;
endpackage

// File: rtl/sc_reg_steer.sv
module sc_reg_steer
  import sc_ctrl_pkg::*;
(
  input  opc_e             opc,
  input  logic [RID_W-1:0] ra,
  input  logic [RID_W-1:0] rb,
  output logic [RID_W-1:0] src_a,
  output logic [RID_W-1:0] src_b,
  output logic [RID_W-1:0] dst_e,
  output logic [RID_W-1:0] dst_m
);
  always_comb begin
    unique case (opc)
      OPC_RRMV, OPC_RMMV, OPC_ALU, OPC_PUSH: src_a = ra;
      OPC_POP, OPC_RET:                      src_a = RID_SP;
      default:                               src_a = RID_NONE;
    endcase
    unique case (opc)
      OPC_ALU, OPC_RMMV, OPC_MRMV:             src_b = rb;
      OPC_PUSH, OPC_POP, OPC_CALL, OPC_RET:    src_b = RID_SP;
      default:                                 src_b = RID_NONE;
    endcase
    unique case (opc)
      OPC_RRMV, OPC_IRMV, OPC_ALU:             dst_e = rb;
      OPC_PUSH, OPC_POP, OPC_CALL, OPC_RET:    dst_e = RID_SP;
      default:                                 dst_e = RID_NONE;
    endcase
    unique case (opc)
      OPC_MRMV, OPC_POP: dst_m = ra;
      default:           dst_m = RID_NONE;
    endcase
  end

  // Stack-class instructions always update the stack pointer (R3)
  always_comb begin
    if (opc == OPC_PUSH || opc == OPC_POP || opc == OPC_CALL || opc == OPC_RET)
      p_stack_dst_r3: assert (dst_e == RID_SP);
  end

  // Pop writes the popped word to rA alongside the stack pointer (R4)
  always_comb begin
    if (opc == OPC_POP)
      p_pop_dual_r4: assert (dst_m == ra && dst_e == RID_SP);
  end
endmodule

// File: rtl/sc_alu_steer.sv
module sc_alu_steer
  import sc_ctrl_pkg::*;
#(
  parameter int unsigned WORD_W = 32
) (
  input  opc_e              opc,
  input  logic [FN_W-1:0]   ifun,
  input  logic [WORD_W-1:0] val_a,
  input  logic [WORD_W-1:0] val_b,
  input  logic [WORD_W-1:0] val_c,
  output logic [WORD_W-1:0] alu_a,
  output logic [WORD_W-1:0] alu_b,
  output logic [FN_W-1:0]   alu_fn,
  output logic              cc_load
);
  localparam logic [WORD_W-1:0] STEP_UP   = WORD_W'(4);
  localparam logic [WORD_W-1:0] STEP_DOWN = ~WORD_W'(3);

  always_comb begin
    unique case (opc)
      OPC_RRMV, OPC_ALU:            alu_a = val_a;
      OPC_IRMV, OPC_RMMV, OPC_MRMV: alu_a = val_c;
      OPC_CALL, OPC_PUSH:           alu_a = STEP_DOWN;
      OPC_RET, OPC_POP:             alu_a = STEP_UP;
      default:                      alu_a = '0;
    endcase
    alu_b   = (opc == OPC_RRMV || opc == OPC_IRMV) ? '0 : val_b;
    cc_load = (opc == OPC_ALU);
    alu_fn  = cc_load ? ifun : FN_ADD;
  end

  // Condition codes only follow an op whose function passes through (R7)
  always_comb begin
    if (cc_load)
      p_cc_fn_r7: assert (alu_fn == ifun);
    else
      p_add_only_r7: assert (alu_fn == FN_ADD);
  end

  // Stack adjust is always a signed step of magnitude four (R5)
  always_comb begin
    if (opc == OPC_PUSH || opc == OPC_CALL)
      p_step_sum_r5: assert (alu_a + STEP_UP == '0);
  end
endmodule

// File: rtl/sc_mem_steer.sv
module sc_mem_steer
  import sc_ctrl_pkg::*;
#(
  parameter int unsigned WORD_W = 32
) (
  input  opc_e              opc,
  input  logic [WORD_W-1:0] val_a,
  input  logic [WORD_W-1:0] val_e,
  input  logic [WORD_W-1:0] val_p,
  output logic              mem_rd,
  output logic              mem_wr,
  output logic [WORD_W-1:0] mem_addr,
  output logic [WORD_W-1:0] mem_wdata
);
  always_comb begin
    mem_rd = (opc == OPC_MRMV) || (opc == OPC_POP) || (opc == OPC_RET);
    mem_wr = (opc == OPC_RMMV) || (opc == OPC_PUSH) || (opc == OPC_CALL);
    unique case (opc)
      OPC_RMMV, OPC_PUSH, OPC_CALL, OPC_MRMV: mem_addr = val_e;
      OPC_POP, OPC_RET:                       mem_addr = val_a;
      default:                                mem_addr = '0;
    endcase
    mem_wdata = (opc == OPC_CALL) ? val_p : val_a;
  end

  // Read and write strobes are never raised together (R8)
  always_comb begin
    p_rd_wr_excl_r8: assert ($onehot0({mem_rd, mem_wr}));
  end
endmodule

// File: rtl/sc_pc_steer.sv
module sc_pc_steer
  import sc_ctrl_pkg::*;
#(
  parameter int unsigned WORD_W = 32
) (
  input  opc_e              opc,
  input  logic              br_taken,
  input  logic [WORD_W-1:0] val_c,
  input  logic [WORD_W-1:0] val_p,
  input  logic [WORD_W-1:0] val_m,
  output logic [WORD_W-1:0] pc_next
);
  always_comb begin
    if (opc == OPC_CALL)                   pc_next = val_c;
    else if (opc == OPC_JMP && br_taken)   pc_next = val_c;
    else if (opc == OPC_RET)               pc_next = val_m;
    else                                   pc_next = val_p;
  end

  // Non-control-flow codes fall through (R10)
  always_comb begin
    if (opc != OPC_CALL && opc != OPC_JMP && opc != OPC_RET)
      p_fallthru_r10: assert (pc_next == val_p);
  end
endmodule

// File: rtl/sc_ctrl_decode.sv
module sc_ctrl_decode
  import sc_ctrl_pkg::*;
#(
  parameter int unsigned WORD_W = 32
) (
  input  logic [3:0]        icode,
  input  logic [3:0]        ifun,
  input  logic [3:0]        ra,
  input  logic [3:0]        rb,
  input  logic [WORD_W-1:0] val_a,
  input  logic [WORD_W-1:0] val_b,
  input  logic [WORD_W-1:0] val_c,
  input  logic [WORD_W-1:0] val_p,
  input  logic [WORD_W-1:0] val_e,
  input  logic [WORD_W-1:0] val_m,
  input  logic              br_taken,
  output logic [3:0]        src_a,
  output logic [3:0]        src_b,
  output logic [3:0]        dst_e,
  output logic [3:0]        dst_m,
  output logic [WORD_W-1:0] alu_a,
  output logic [WORD_W-1:0] alu_b,
  output logic [3:0]        alu_fn,
  output logic              cc_load,
  output logic              mem_rd,
  output logic              mem_wr,
  output logic [WORD_W-1:0] mem_addr,
  output logic [WORD_W-1:0] mem_wdata,
  output logic [WORD_W-1:0] pc_next
);
  opc_e opc;
  assign opc = opc_e'(icode);

  sc_reg_steer u_reg (
    .opc(opc), .ra(ra), .rb(rb),
    .src_a(src_a), .src_b(src_b), .dst_e(dst_e), .dst_m(dst_m)
  );

  sc_alu_steer #(.WORD_W(WORD_W)) u_alu (
    .opc(opc), .ifun(ifun), .val_a(val_a), .val_b(val_b), .val_c(val_c),
    .alu_a(alu_a), .alu_b(alu_b), .alu_fn(alu_fn), .cc_load(cc_load)
  );

  sc_mem_steer #(.WORD_W(WORD_W)) u_mem (
    .opc(opc), .val_a(val_a), .val_e(val_e), .val_p(val_p),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_addr(mem_addr), .mem_wdata(mem_wdata)
  );

  sc_pc_steer #(.WORD_W(WORD_W)) u_pc (
    .opc(opc), .br_taken(br_taken), .val_c(val_c), .val_p(val_p), .val_m(val_m),
    .pc_next(pc_next)
  );

  // Codes with no architectural effect leave every write path idle (R11)
  always_comb begin
    if (icode <= 4'h1 || icode >= 4'hC)
      p_idle_code_r11: assert (!mem_rd && !mem_wr && !cc_load &&
                               dst_e == RID_NONE && dst_m == RID_NONE);
  end
endmodule

// File: tb/sc_ctrl_decode_tb_top.sv
module sc_ctrl_decode_tb_top;
  localparam int W = 32;

  logic clk;
  logic rst_n;
  logic [3:0] icode, ifun, ra, rb;
  logic [W-1:0] val_a, val_b, val_c, val_p, val_e, val_m;
  logic br_taken;
  logic [3:0] src_a, src_b, dst_e, dst_m, alu_fn;
  logic [W-1:0] alu_a, alu_b, mem_addr, mem_wdata, pc_next;
  logic cc_load, mem_rd, mem_wr;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  sc_ctrl_decode #(.WORD_W(W)) dut_i (
    .icode(icode), .ifun(ifun), .ra(ra), .rb(rb),
    .val_a(val_a), .val_b(val_b), .val_c(val_c), .val_p(val_p),
    .val_e(val_e), .val_m(val_m), .br_taken(br_taken),
    .src_a(src_a), .src_b(src_b), .dst_e(dst_e), .dst_m(dst_m),
    .alu_a(alu_a), .alu_b(alu_b), .alu_fn(alu_fn), .cc_load(cc_load),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .pc_next(pc_next)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic check(input string req, input string what,
                       input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  // Behavioural reference: one opcode class at a time
  task automatic compare_all();
    int c;
    bit stk, none;
    longint e_sa, e_sb, e_de, e_dm, e_aa, e_ab, e_fn, e_addr, e_wd, e_pc;
    bit e_cc, e_rd, e_wr;
    c = int'(icode);
    stk  = (c == 8 || c == 9 || c == 10 || c == 11);
    none = (c <= 1 || c >= 12);
    e_sa = (c == 2 || c == 4 || c == 6 || c == 10) ? ra :
           (c == 9 || c == 11) ? 4 : 15;
    e_sb = (c == 6 || c == 4 || c == 5) ? rb : stk ? 4 : 15;
    e_de = (c == 2 || c == 3 || c == 6) ? rb : stk ? 4 : 15;
    e_dm = (c == 5 || c == 11) ? ra : 15;
    if (c == 2 || c == 6)                 e_aa = val_a;
    else if (c == 3 || c == 4 || c == 5)  e_aa = val_c;
    else if (c == 8 || c == 10)           e_aa = 32'hFFFF_FFFC;
    else if (c == 9 || c == 11)           e_aa = 4;
    else                                  e_aa = 0;
    e_ab = (c == 2 || c == 3) ? 0 : val_b;
    e_cc = (c == 6);
    e_fn = e_cc ? ifun : 0;
    e_rd = (c == 5 || c == 11 || c == 9);
    e_wr = (c == 4 || c == 10 || c == 8);
    e_addr = (c == 4 || c == 10 || c == 8 || c == 5) ? val_e :
             (c == 11 || c == 9) ? val_a : 0;
    e_wd = (c == 8) ? val_p : val_a;
    if (c == 8 || (c == 7 && br_taken)) e_pc = val_c;
    else if (c == 9)                    e_pc = val_m;
    else                                e_pc = val_p;

    check("R1", "src_a", src_a, e_sa);
    check("R2", "src_b", src_b, e_sb);
    check("R3", "dst_e", dst_e, e_de);
    check("R4", "dst_m", dst_m, e_dm);
    check("R5", "alu_a", alu_a, e_aa);
    check("R6", "alu_b", alu_b, e_ab);
    check("R7", "alu_fn", alu_fn, e_fn);
    check("R7", "cc_load", cc_load, e_cc);
    check("R8", "mem_rd", mem_rd, e_rd);
    check("R8", "mem_wr", mem_wr, e_wr);
    check("R9", "mem_addr", mem_addr, e_addr);
    check("R9", "mem_wdata", mem_wdata, e_wd);
    check("R10", "pc_next", pc_next, e_pc);
    if (none)
      check("R11", "idle write/access",
            {dst_e, dst_m, 1'b0, cc_load, mem_rd, mem_wr}, {8'hFF, 4'b0000});
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    icode = 4'h1; ifun = 4'h0; ra = 4'hF; rb = 4'hF; br_taken = 1'b0;
    val_a = 32'h11; val_b = 32'h22; val_c = 32'h33;
    val_p = 32'h44; val_e = 32'h55; val_m = 32'h66;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // Reset-state vector: nop decoding (R11)
    check("R11", "reset nop pc_next", pc_next, 32'h44);
    compare_all();

    for (int p = 0; p < 8; p++) begin
      for (int c = 0; c < 16; c++) begin
        @(posedge clk);
        #1;
        icode = 4'(c);
        ifun  = 4'(p + c);
        case (p % 4)
          0: begin ra = 4'h1; rb = 4'h3; end
          1: begin ra = 4'h4; rb = 4'h7; end
          2: begin ra = 4'hF; rb = 4'h4; end
          default: begin ra = 4'h6; rb = 4'hF; end
        endcase
        br_taken = p[0];
        val_a = 32'hA000_0000 + 32'(p * 256 + c);
        val_b = 32'hB000_0000 + 32'(p * 256 + c);
        val_c = 32'hC000_0000 + 32'(p * 256 + c);
        val_p = 32'hD000_0000 + 32'(p * 256 + c);
        val_e = 32'hE000_0000 + 32'(p * 256 + c);
        val_m = 32'hF000_0000 + 32'(p * 256 + c);
        @(negedge clk);
        compare_all();
      end
    end

    // Jump boundary: same vector, flag low then high (R10)
    @(posedge clk); #1;
    icode = 4'h7; br_taken = 1'b0; val_c = 32'h1234; val_p = 32'h5678;
    @(negedge clk);
    check("R10", "jump not taken", pc_next, 32'h5678);
    @(posedge clk); #1;
    br_taken = 1'b1;
    @(negedge clk);
    check("R10", "jump taken", pc_next, 32'h1234);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule